// File: doc/BRIEF.md
# Stepped Frequency Sweep Controller

This block sets the frequency word for a direct digital synthesiser in a bench signal generator. It has two modes. In the tuning modes (unmodulated carrier, AM and three FM deviation widths) the encoder moves a single tuned frequency by a decade step that the user picks. In scan mode the block runs the synthesiser through a series of discrete frequencies between a start and a stop value. The user watches a filter's response on an oscilloscope and aligns the filter while the sweep repeats.

The inputs are one-cycle pulses that have already been debounced: a mode button, a step button, encoder up and down pulses, and a dwell tick. Pressing mode and step in the same cycle counts as one scan press. Repeated scan presses walk through a set-up sequence: edit the start frequency, edit the stop frequency, choose the number of points, then run. The step between points is the start-to-stop span divided by the chosen point count. A serial divider computes it when the run begins.

Top module: `sweep_scan_ctrl`

## Requirements
- R1: After reset, mode is 0 (CW), setup_field is 0 (idle), freq_hz is 10000000 and freq_valid is low.
- R2: A mode press alone, with step low, moves the mode through CW=0, AM=1, narrow FM=2, wide FM=3, broadcast FM=4, scan=5. Entering scan (5) sets setup_field to 1. A mode press while in scan returns to CW with setup_field 0.
- R3: A scan press is mode and step high in the same cycle. From any non-scan mode it enters scan with setup_field 1 (start edit). Each further press advances the field: start edit 1 → stop edit 2 → count edit 3 → step calculation 4, after which the field reaches run 5 by itself. A scan press during run returns to start edit 1. setup_field is non-zero exactly when the mode is scan.
- R4: Outside scan mode, each encoder pulse raises or lowers the tuned frequency by the tuning step. A step press alone moves the tuning step through 10, 100, 1k, 10k, 100k, 1M Hz and then wraps to 10 Hz. The step after reset is 1 kHz.
- R5: No encoder action takes any frequency outside 100000..150000000 Hz. An action that would go past a limit stops at the limit.
- R6: In start edit and stop edit, each encoder pulse moves the value being edited by 1000 Hz, and freq_hz shows that value. Start is at most 149999000 Hz. After reset, start is 1000000 Hz and stop is 2000000 Hz.
- R7: In count edit, the encoder moves through the point counts 10, 20, 50, 100, 200, 500. It stops at both ends of the list and does not wrap. After reset the count is 10.
- R8: When run begins, freq_hz is the start value. The step is floor((stop − start)/N) Hz for N points. Every DWELL_TICKS dwell ticks the frequency rises by one step. After point N−1 it goes back to the start value.
- R9: If stop is not above start when run begins, stop is set to start + 1000 Hz.
- R10: During run, encoder pulses and lone step presses change nothing. Leaving scan mode restores the tuned frequency as it was before scan mode was entered.
- R11: freq_valid is high for one cycle each time freq_hz takes a new value, and is low when an action leaves freq_hz unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_btn | input | 1 | Debounced mode button pulse |
| step_btn | input | 1 | Debounced step button pulse |
| enc_up | input | 1 | Encoder clockwise pulse |
| enc_dn | input | 1 | Encoder counter-clockwise pulse |
| dwell_tick | input | 1 | Dwell time base pulse |
| freq_hz | output | FW | Current output frequency in Hz |
| freq_valid | output | 1 | One-cycle strobe when freq_hz changes |
| mode | output | 3 | Operating mode code |
| setup_field | output | 3 | Scan set-up field code |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- every frequency stays inside the allowed range;
- every change of freq_hz comes with a strobe;
- the field is non-zero only in scan mode, and run is entered only from the calculation field;
- stop is above start while running, and each sweep point lies inside the start-to-stop window;
- the divider's quotient and remainder rebuild its dividend;
- the dwell counter stays below its limit.

Only the bench scenarios can show the values that depend on history:
- the exact tuned frequencies after decade changes and clamping;
- the mode order;
- the full sweep sequence and its wrap back to start;
- the forced stop value;
- the tuned frequency being restored after leaving scan mode.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int FREQ_W      = 28;
  localparam int FREQ_MIN    = 100_000;
  localparam int FREQ_MAX    = 150_000_000;
  localparam int FREQ_INIT   = 10_000_000;
  localparam int EDIT_STEP   = 1000;
  localparam int START_INIT  = 1_000_000;
  localparam int STOP_INIT   = 2_000_000;
  localparam int NUM_COUNTS  = 6;
  localparam int NUM_DECADES = 6;
  localparam int SEL_W       = 3;
  localparam int CNT_W       = 10;

  typedef enum logic [2:0] {
    MD_CW   = 3'd0,
    MD_AM   = 3'd1,
    MD_FMN  = 3'd2,
    MD_FMW  = 3'd3,
    MD_FMB  = 3'd4,
    MD_SCAN = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    FLD_IDLE  = 3'd0,
    FLD_START = 3'd1,
    FLD_STOP  = 3'd2,
    FLD_COUNT = 3'd3,
    FLD_CALC  = 3'd4,
    FLD_RUN   = 3'd5
  } field_e;

  function automatic logic [CNT_W-1:0] count_of(logic [SEL_W-1:0] idx);
    case (idx)
      3'd0:    count_of = 10'd10;
      3'd1:    count_of = 10'd20;
      3'd2:    count_of = 10'd50;
      3'd3:    count_of = 10'd100;
      3'd4:    count_of = 10'd200;
      default: count_of = 10'd500;
    endcase
  endfunction

  function automatic int decade_of(logic [SEL_W-1:0] idx);
    int v;
    v = 10;
    for (int i = 0; i < NUM_DECADES - 1; i++) begin
      if (i < int'(idx)) v = v * 10;
    end
    return v;
  endfunction
endpackage

// File: rtl/sweep_tuner.sv
module sweep_tuner
  import sweep_pkg::*;
#(
  parameter int FW = FREQ_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          up,
  input  logic          dn,
  input  logic          step_adv,
  output logic [FW-1:0] freq
);
  localparam logic [FW-1:0]    F_LO     = FW'(FREQ_MIN);
  localparam logic [FW-1:0]    F_HI     = FW'(FREQ_MAX);
  localparam logic [SEL_W-1:0] DEC_LAST = SEL_W'(NUM_DECADES - 1);

  logic [SEL_W-1:0] dec_q;
  logic [FW-1:0]    inc;

  assign inc = FW'(decade_of(dec_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      freq  <= FW'(FREQ_INIT);
      dec_q <= SEL_W'(2);
    end else if (en) begin
      if (step_adv) dec_q <= (dec_q == DEC_LAST) ? '0 : dec_q + SEL_W'(1);
      if (up && !dn)      freq <= (freq > F_HI - inc) ? F_HI : freq + inc;
      else if (dn && !up) freq <= (freq < F_LO + inc) ? F_LO : freq - inc;
    end
  end

  assert_tune_range_R5: assert property (@(posedge clk) disable iff (rst)
    (freq >= F_LO) && (freq <= F_HI));

  assert_tune_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(freq));
endmodule

// File: rtl/sweep_dwell.sv
module sweep_dwell #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic adv
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign adv = run && tick && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (adv)     cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CW'(1);
  end

  assert_dwell_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(TICKS));
endmodule

// File: rtl/sweep_divider.sv
module sweep_divider #(
  parameter int NW = 28,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int IW = $clog2(NW + 1);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [NW-1:0] acc_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] den_q;
  logic [NW-1:0] num_q;
  logic [DW:0]   shifted;
  logic [DW:0]   diff;
  logic          fits;

  assign shifted = {rem_q, acc_q[NW-1]};
  assign fits    = shifted >= {1'b0, den_q};
  assign diff    = shifted - {1'b0, den_q};
  assign quot    = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= num;
        rem_q  <= '0;
        den_q  <= den;
        num_q  <= num;
      end else if (busy_q) begin
        rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
        acc_q <= {acc_q[NW-2:0], fits};
        idx_q <= idx_q + IW'(1);
        if (idx_q == IW'(NW - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assert_div_exact_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{DW{1'b0}}, acc_q} * {{NW{1'b0}}, den_q}) + {{NW{1'b0}}, rem_q})
             == {{DW{1'b0}}, num_q});
endmodule

// File: rtl/sweep_scan_ctrl.sv
module sweep_scan_ctrl
  import sweep_pkg::*;
#(
  parameter int FW          = FREQ_W,
  parameter int DWELL_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_btn,
  input  logic          step_btn,
  input  logic          enc_up,
  input  logic          enc_dn,
  input  logic          dwell_tick,
  output logic [FW-1:0] freq_hz,
  output logic          freq_valid,
  output logic [2:0]    mode,
  output logic [2:0]    setup_field
);
  localparam logic [FW-1:0]    F_LO      = FW'(FREQ_MIN);
  localparam logic [FW-1:0]    F_HI      = FW'(FREQ_MAX);
  localparam logic [FW-1:0]    F_EDIT    = FW'(EDIT_STEP);
  localparam logic [FW-1:0]    START_HI  = F_HI - F_EDIT;
  localparam logic [SEL_W-1:0] CNT_LAST  = SEL_W'(NUM_COUNTS - 1);

  mode_e            mode_q;
  field_e           field_q;
  logic [FW-1:0]    start_q, stop_q, run_q, nxt_freq, tune_f, span, step_f;
  logic [SEL_W-1:0] csel_q;
  logic [CNT_W-1:0] k_q, npts;
  logic             div_go_q, div_done, adv;
  logic             ev_scan, ev_mode, ev_step, ev_up, ev_dn;

  assign ev_scan = mode_btn && step_btn;
  assign ev_mode = mode_btn && !step_btn;
  assign ev_step = step_btn && !mode_btn;
  assign ev_up   = enc_up && !enc_dn;
  assign ev_dn   = enc_dn && !enc_up;
  assign npts    = count_of(csel_q);
  assign span    = stop_q - start_q;

  sweep_tuner #(.FW(FW)) u_tuner (
    .clk(clk), .rst(rst), .en(mode_q != MD_SCAN), .up(enc_up), .dn(enc_dn),
    .step_adv(ev_step), .freq(tune_f)
  );

  sweep_divider #(.NW(FW), .DW(CNT_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go_q), .num(span), .den(npts),
    .done(div_done), .quot(step_f)
  );

  sweep_dwell #(.TICKS(DWELL_TICKS)) u_dwell (
    .clk(clk), .rst(rst), .run(field_q == FLD_RUN), .tick(dwell_tick), .adv(adv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_CW;
      field_q  <= FLD_IDLE;
      start_q  <= FW'(START_INIT);
      stop_q   <= FW'(STOP_INIT);
      csel_q   <= '0;
      run_q    <= FW'(START_INIT);
      k_q      <= '0;
      div_go_q <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      if (ev_mode) begin
        if (mode_q == MD_SCAN) begin
          mode_q  <= MD_CW;
          field_q <= FLD_IDLE;
        end else if (mode_q == MD_FMB) begin
          mode_q  <= MD_SCAN;
          field_q <= FLD_START;
        end else begin
          mode_q <= mode_e'(mode_q + 3'd1);
        end
      end else if (ev_scan) begin
        case (field_q)
          FLD_IDLE:  begin mode_q <= MD_SCAN; field_q <= FLD_START; end
          FLD_START: field_q <= FLD_STOP;
          FLD_STOP:  field_q <= FLD_COUNT;
          FLD_COUNT: begin
            if (stop_q <= start_q) stop_q <= start_q + F_EDIT;
            field_q  <= FLD_CALC;
            div_go_q <= 1'b1;
          end
          FLD_RUN:   field_q <= FLD_START;
          default:   field_q <= field_q;
        endcase
      end else if (div_done && field_q == FLD_CALC) begin
        field_q <= FLD_RUN;
        run_q   <= start_q;
        k_q     <= '0;
      end else if (field_q == FLD_RUN && adv) begin
        if (k_q == npts - CNT_W'(1)) begin
          k_q   <= '0;
          run_q <= start_q;
        end else begin
          k_q   <= k_q + CNT_W'(1);
          run_q <= run_q + step_f;
        end
      end else if (field_q == FLD_START) begin
        if (ev_up)      start_q <= (start_q > START_HI - F_EDIT) ? START_HI : start_q + F_EDIT;
        else if (ev_dn) start_q <= (start_q < F_LO + F_EDIT) ? F_LO : start_q - F_EDIT;
      end else if (field_q == FLD_STOP) begin
        if (ev_up)      stop_q <= (stop_q > F_HI - F_EDIT) ? F_HI : stop_q + F_EDIT;
        else if (ev_dn) stop_q <= (stop_q < F_LO + F_EDIT) ? F_LO : stop_q - F_EDIT;
      end else if (field_q == FLD_COUNT) begin
        if (ev_up && csel_q != CNT_LAST)   csel_q <= csel_q + SEL_W'(1);
        else if (ev_dn && csel_q != '0)    csel_q <= csel_q - SEL_W'(1);
      end
    end
  end

  always_comb begin
    if (mode_q != MD_SCAN) nxt_freq = tune_f;
    else begin
      case (field_q)
        FLD_START: nxt_freq = start_q;
        FLD_STOP:  nxt_freq = stop_q;
        FLD_RUN:   nxt_freq = run_q;
        default:   nxt_freq = freq_hz;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_hz    <= FW'(FREQ_INIT);
      freq_valid <= 1'b0;
    end else begin
      freq_hz    <= nxt_freq;
      freq_valid <= nxt_freq != freq_hz;
    end
  end

  assign mode        = mode_q;
  assign setup_field = field_q;

  assert_freq_range_R5: assert property (@(posedge clk) disable iff (rst)
    (freq_hz >= F_LO) && (freq_hz <= F_HI));

  assert_strobe_on_change_R11: assert property (@(posedge clk) disable iff (rst)
    (freq_hz != $past(freq_hz)) |-> freq_valid);

  assert_field_scan_only_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_SCAN) == (field_q != FLD_IDLE));

  assert_run_after_calc_R3: assert property (@(posedge clk) disable iff (rst)
    (field_q == FLD_RUN && $past(field_q) != FLD_RUN) |-> $past(field_q) == FLD_CALC);

  assert_stop_above_start_R9: assert property (@(posedge clk) disable iff (rst)
    (field_q == FLD_RUN) |-> (stop_q > start_q));

  assert_run_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    (field_q == FLD_RUN) |-> (run_q >= start_q && run_q < stop_q));

  assert_count_index_R7: assert property (@(posedge clk) disable iff (rst)
    csel_q <= CNT_LAST);
endmodule

// File: tb/sweep_scan_ctrl_test.sv
`timescale 1ns/1ps
module sweep_scan_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_btn = 1'b0, step_btn = 1'b0, enc_up = 1'b0, enc_dn = 1'b0, dwell_tick = 1'b0;
  logic [27:0] freq_hz;
  logic        freq_valid;
  logic [2:0]  mode, setup_field;

  localparam int DWELL = 4;

  always #5 clk = ~clk;

  sweep_scan_ctrl #(.FW(28), .DWELL_TICKS(DWELL)) uut (
    .clk(clk), .rst(rst), .mode_btn(mode_btn), .step_btn(step_btn),
    .enc_up(enc_up), .enc_dn(enc_dn), .dwell_tick(dwell_tick),
    .freq_hz(freq_hz), .freq_valid(freq_valid), .mode(mode), .setup_field(setup_field)
  );

  typedef struct {
    int    f;
    int    m;
    int    s;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, strobes = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    #2;
    if (!rst && freq_valid) strobes++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      wait (q.size() != 0);
      checks++;
      if (int'(freq_hz) != q[0].f || int'(mode) != q[0].m || int'(setup_field) != q[0].s) begin
        fails++;
        $display("FAIL %s actual freq=%0d mode=%0d field=%0d expected freq=%0d mode=%0d field=%0d",
                 q[0].tag, freq_hz, mode, setup_field, q[0].f, q[0].m, q[0].s);
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_state(input int f, input int m, input int s, input string tag);
    exp_t e;
    e.f = f; e.m = m; e.s = s; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic pulse(input bit mb, input bit sb, input bit up, input bit dn, input bit tk);
    @(negedge clk);
    mode_btn = mb; step_btn = sb; enc_up = up; enc_dn = dn; dwell_tick = tk;
    @(negedge clk);
    mode_btn = 0; step_btn = 0; enc_up = 0; enc_dn = 0; dwell_tick = 0;
    @(negedge clk);
  endtask

  task automatic press_mode();  pulse(1, 0, 0, 0, 0); endtask
  task automatic press_step();  pulse(0, 1, 0, 0, 0); endtask
  task automatic press_scan();  pulse(1, 1, 0, 0, 0); endtask
  task automatic turn_up();     pulse(0, 0, 1, 0, 0); endtask
  task automatic turn_dn();     pulse(0, 0, 0, 1, 0); endtask
  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) pulse(0, 0, 0, 0, 1);
  endtask

  task automatic wait_run(input string req);
    int n;
    n = 0;
    while (setup_field != 3'd5 && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(setup_field == 3'd5, req, int'(setup_field), 5);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    int step_a;
    int start_a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_state(10_000_000, 0, 0, "R1 reset");
    check(freq_valid == 1'b0, "R1 strobe low after reset", int'(freq_valid), 0);

    // R4 tuning, R11 strobe
    s0 = strobes;
    turn_up();
    expect_state(10_001_000, 0, 0, "R4 tune up 1k");
    check(strobes - s0 == 1, "R11 one strobe per change", strobes - s0, 1);
    press_step(); press_step();
    turn_dn();
    expect_state(9_901_000, 0, 0, "R4 tune down 100k");
    press_step(); press_step(); press_step();
    turn_up();
    expect_state(9_901_100, 0, 0, "R4 decade wrap to 100 Hz");
    repeat (4) press_step();
    repeat (10) turn_dn();
    expect_state(100_000, 0, 0, "R5 low clamp");
    s0 = strobes;
    turn_dn();
    expect_state(100_000, 0, 0, "R5 hold at low limit");
    check(strobes == s0, "R11 no strobe when unchanged", strobes - s0, 0);
    repeat (160) turn_up();
    expect_state(150_000_000, 0, 0, "R5 high clamp");

    // R2 mode order
    for (int m = 1; m <= 4; m++) begin
      press_mode();
      expect_state(150_000_000, m, 0, "R2 mode cycle");
    end
    press_mode();
    expect_state(1_000_000, 5, 1, "R2 enter scan from broadcast FM");
    press_mode();
    expect_state(150_000_000, 0, 0, "R10 tuned frequency restored");

    // R3 set-up sequence, R6 edit
    press_scan();
    expect_state(1_000_000, 5, 1, "R3 scan press from CW");
    repeat (3) turn_up();
    expect_state(1_003_000, 5, 1, "R6 start edit");
    press_scan();
    expect_state(2_000_000, 5, 2, "R3 stop edit field");
    press_scan();
    expect_state(2_000_000, 5, 3, "R3 count edit field");
    turn_dn();
    turn_up();
    press_scan();
    wait_run("R3 reaches run");
    start_a = 1_003_000;
    step_a  = (2_000_000 - 1_003_000) / 20;
    expect_state(start_a, 5, 5, "R8 run starts at start");

    // R10 ignored inputs during run
    turn_up();
    press_step();
    expect_state(start_a, 5, 5, "R10 encoder and step ignored in run");

    // R8 sweep
    tick_n(DWELL - 1);
    expect_state(start_a, 5, 5, "R8 dwell not yet elapsed");
    tick_n(1);
    expect_state(start_a + step_a, 5, 5, "R8 first step");
    for (int k = 2; k < 20; k++) begin
      tick_n(DWELL);
      expect_state(start_a + k * step_a, 5, 5, "R8 sweep point");
    end
    tick_n(DWELL);
    expect_state(start_a, 5, 5, "R8 wrap to start");

    // R9 forced stop, R7 saturation
    press_scan();
    expect_state(start_a, 5, 1, "R3 scan in run returns to start edit");
    press_scan();
    expect_state(2_000_000, 5, 2, "R3 stop edit again");
    repeat (1000) turn_dn();
    expect_state(1_000_000, 5, 2, "R6 stop edit down");
    press_scan();
    repeat (6) turn_up();
    press_scan();
    wait_run("R9 reaches run");
    expect_state(start_a, 5, 5, "R9 run start");
    tick_n(DWELL);
    expect_state(start_a + 2, 5, 5, "R9 R7 step from forced stop with 500 points");

    press_mode();
    expect_state(150_000_000, 0, 0, "R2 mode leaves scan");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule